// File: doc/BRIEF.md
# Low-Power Wake-Up Source Controller

This block decides when and how the chip leaves its two low-power states, stop and sleep. Every clock it looks at the current low-power state, five wake event lines and an enable mask, and decides whether any of the events counts as a wake. The five lines are the switch inputs without cyclic sensing, the cyclic-sense inputs, the forced timer wake, chip-select activity and the LIN bus wake. A wake is accepted only if its line is asserted, its enable bit is set, and the current state allows that source. Sleep refuses chip-select activity, while stop accepts every source.

The external reset pin also works as a wake source, but only in stop. It has to stay low through a glitch filter whose length is set by a parameter in clock cycles. This wake is silent: it raises no interrupt and sets no flag. It leads to normal-request mode when the watchdog is enabled, and to normal mode when the watchdog is disabled.

Any other wake from stop leads to normal-request mode, raises an interrupt and latches a flag for each source that woke the chip. A wake from sleep always asks for a pass through reset, because the processor has no supply in that state. Software clears the latched flags with a read strobe.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, `wake_req_o` and `irq_o` are 0, `wake_flags_o` is 0 and `next_mode_o` is 0.
- R2: In stop (`lp_mode_i`=1), an enabled event on any source leads to the following outputs one clock after it is sampled. `wake_req_o` pulses for one cycle, `next_mode_o` becomes 1 (normal-request) and `irq_o` pulses with it. The matching flag bit is set. Source bits: 0 switch, 1 cyclic sense, 2 timer, 3 chip select, 4 LIN.
- R3: In sleep (`lp_mode_i`=2), an enabled event on bit 0, 1, 2 or 4 pulses `wake_req_o` one clock later and sets `next_mode_o` to 2 (reset first). It latches the flag and leaves `irq_o` at 0.
- R4: In sleep, an event on bit 3 (chip select) produces no request and sets no flag.
- R5: An event on a source whose `src_en_i` bit is 0 produces no request and no flag, in both stop and sleep.
- R6: In stop, `rst_pin_n_i` has to be sampled low for FILT_LEN consecutive clocks to count as a wake. A shorter low pulse does nothing. A high sample restarts the count.
- R7: A reset-pin wake sets `next_mode_o` to 0 (normal) when `wd_off_i`=1 and to 1 when `wd_off_i`=0. It pulses `wake_req_o` without `irq_o` and sets no flag.
- R8: In sleep, the reset pin is ignored however long it stays low.
- R9: Events arriving in the same cycle latch all of their flags together and produce a single request pulse.
- R10: Once a request has been issued, no further request is made until `lp_mode_i` leaves the low-power codes (values 0 or 3 mean active).
- R11: Flags stay set until `flag_rd_i` is sampled high, which clears them one clock later. A flag set in the same cycle as the read survives.
- R12: While `lp_mode_i` is active, events and the reset pin have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_mode_i | input | 2 | Current mode: 0 active, 1 stop, 2 sleep, 3 active |
| evt_i | input | 5 | Wake event lines, one per source |
| src_en_i | input | 5 | Per-source wake enable |
| rst_pin_n_i | input | 1 | External reset pin level, low active |
| wd_off_i | input | 1 | Watchdog disabled by configuration |
| flag_rd_i | input | 1 | Read strobe that clears the wake flags |
| wake_req_o | output | 1 | One-cycle request to change mode |
| next_mode_o | output | 2 | Requested mode: 0 normal, 1 normal-request, 2 reset |
| irq_o | output | 1 | One-cycle wake interrupt |
| wake_flags_o | output | 5 | Latched wake sources |

## Verification
The request, next mode, interrupt and flag updates are all registered once, so each one appears on the clock edge after the edge that samples the event. The reset-pin wake appears one clock after its FILT_LEN-th consecutive low sample. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from the same sampled inputs. All four outputs are compared with the model on the next falling edge, so each comparison lands exactly one register stage after the stimulus it depends on.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;
    localparam int NSRC   = 5;
    localparam int SRC_SW  = 0;
    localparam int SRC_CYC = 1;
    localparam int SRC_TMR = 2;
    localparam int SRC_CS  = 3;
    localparam int SRC_LIN = 4;

    localparam logic [1:0] LP_STOP  = 2'd1;
    localparam logic [1:0] LP_SLEEP = 2'd2;

    localparam logic [1:0] NX_NORMAL = 2'd0;
    localparam logic [1:0] NX_NREQ   = 2'd1;
    localparam logic [1:0] NX_RESET  = 2'd2;

    typedef struct packed {
        logic            done;
        logic            req;
        logic [1:0]      nxt;
        logic            irq;
        logic [NSRC-1:0] flags;
    } wake_st_t;
endpackage

// File: rtl/lp_wake_gate.sv
module lp_wake_gate #(
    parameter int NSRC   = 5,
    parameter int CS_IDX = 3
) (
    input  logic            in_stop_i,
    input  logic            in_sleep_i,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] acc_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam bit SLEEP_OK = (i != CS_IDX);
        assign acc_o[i] = evt_i[i] & en_i[i] & (in_stop_i | (in_sleep_i & SLEEP_OK));
    end
endmodule

// File: rtl/lp_wake_glitch.sv
module lp_wake_glitch #(
    parameter int FILT_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic pin_n_i,
    output logic fire_o
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        fire_o = arm_i & ~pin_n_i & (cnt_q == LAST);
        if (!arm_i || pin_n_i || fire_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
    import lp_wake_pkg::*;
#(
    parameter int FILT_LEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      lp_mode_i,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] src_en_i,
    input  logic            rst_pin_n_i,
    input  logic            wd_off_i,
    input  logic            flag_rd_i,
    output logic            wake_req_o,
    output logic [1:0]      next_mode_o,
    output logic            irq_o,
    output logic [NSRC-1:0] wake_flags_o
);
    wake_st_t        st_d, st_q;
    logic            in_stop, in_sleep, armed;
    logic [NSRC-1:0] acc;
    logic            pin_wake;

    assign in_stop  = (lp_mode_i == LP_STOP);
    assign in_sleep = (lp_mode_i == LP_SLEEP);
    assign armed    = (in_stop | in_sleep) & ~st_q.done;

    lp_wake_gate #(.NSRC(NSRC), .CS_IDX(SRC_CS)) u_gate (
        .in_stop_i  (armed & in_stop),
        .in_sleep_i (armed & in_sleep),
        .evt_i      (evt_i),
        .en_i       (src_en_i),
        .acc_o      (acc)
    );

    lp_wake_glitch #(.FILT_LEN(FILT_LEN)) u_glitch (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (armed & in_stop),
        .pin_n_i (rst_pin_n_i),
        .fire_o  (pin_wake)
    );

    always_comb begin
        logic any_src;
        logic any_wake;
        any_src  = |acc;
        any_wake = any_src | pin_wake;
        st_d     = st_q;

        st_d.req = any_wake;
        st_d.irq = any_src & in_stop;
        if (any_wake) begin
            if (in_sleep) begin
                st_d.nxt = NX_RESET;
            end else if (any_src || !wd_off_i) begin
                st_d.nxt = NX_NREQ;
            end else begin
                st_d.nxt = NX_NORMAL;
            end
        end

        st_d.done  = (in_stop | in_sleep) & (st_q.done | any_wake);
        st_d.flags = (flag_rd_i ? '0 : st_q.flags) | acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_req_o   = st_q.req;
    assign next_mode_o  = st_q.nxt;
    assign irq_o        = st_q.irq;
    assign wake_flags_o = st_q.flags;
endmodule

// File: rtl/lp_wake_ctrl_chk.sv
module lp_wake_ctrl_chk
    import lp_wake_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      lp_mode_i,
    input logic [NSRC-1:0] evt_i,
    input logic [NSRC-1:0] src_en_i,
    input logic            wd_off_i,
    input logic            flag_rd_i,
    input logic            wake_req_o,
    input logic [1:0]      next_mode_o,
    input logic            irq_o,
    input logic [NSRC-1:0] wake_flags_o
);
    p_irq_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_req_o);

    p_sleep_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && $past(lp_mode_i) == LP_SLEEP) |-> (next_mode_o == NX_RESET && !irq_o));

    p_cs_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lp_mode_i) == LP_SLEEP && !$past(wake_flags_o[SRC_CS])) |-> !wake_flags_o[SRC_CS]);

    p_pin_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && $past(lp_mode_i) == LP_STOP && ($past(evt_i) & $past(src_en_i)) == '0)
        |-> (!irq_o && next_mode_o == ($past(wd_off_i) ? NX_NORMAL : NX_NREQ)));

    p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o);

    p_rd_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd_i |=> ((wake_flags_o & ~$past(evt_i)) == '0));

    p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rd_i |=> (($past(wake_flags_o) & ~wake_flags_o) == '0));

    p_active_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> ($past(lp_mode_i) == LP_STOP || $past(lp_mode_i) == LP_SLEEP));
endmodule

bind lp_wake_ctrl lp_wake_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lp_mode_i    (lp_mode_i),
    .evt_i        (evt_i),
    .src_en_i     (src_en_i),
    .wd_off_i     (wd_off_i),
    .flag_rd_i    (flag_rd_i),
    .wake_req_o   (wake_req_o),
    .next_mode_o  (next_mode_o),
    .irq_o        (irq_o),
    .wake_flags_o (wake_flags_o)
);

// File: tb/tb_lp_wake_ctrl.sv
module tb_lp_wake_ctrl;
    localparam int FL = 4;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] mode = 0;
    logic [4:0] evt = 0;
    logic [4:0] en = 5'h1f;
    logic       pin_n = 1;
    logic       wd_off = 0;
    logic       rd = 0;
    logic       req;
    logic [1:0] nxt;
    logic       irq;
    logic [4:0] flags;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R1";

    bit       e_req, e_irq, m_done;
    bit [1:0] e_nxt;
    bit [4:0] e_flags;
    int       m_low;

    always #5 clk = ~clk;

    lp_wake_ctrl #(.FILT_LEN(FL)) dut (
        .clk(clk), .rst_n(rst_n), .lp_mode_i(mode), .evt_i(evt), .src_en_i(en),
        .rst_pin_n_i(pin_n), .wd_off_i(wd_off), .flag_rd_i(rd),
        .wake_req_o(req), .next_mode_o(nxt), .irq_o(irq), .wake_flags_o(flags)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_req = 0; e_irq = 0; e_nxt = 0; e_flags = 0; m_done = 0; m_low = 0;
        end else begin
            bit       lowp, pw;
            bit [4:0] ok;
            lowp = (mode == 1) || (mode == 2);
            ok = 0;
            for (int i = 0; i < 5; i++) begin
                if (lowp && !m_done && evt[i] && en[i] && (mode == 1 || i != 3)) ok[i] = 1;
            end
            pw = 0;
            if (mode == 1 && !m_done && !pin_n) begin
                m_low++;
                if (m_low >= FL) begin pw = 1; m_low = 0; end
            end else begin
                m_low = 0;
            end
            e_req = (ok != 0) || pw;
            e_irq = (ok != 0) && mode == 1;
            if (e_req) begin
                if (mode == 2) e_nxt = 2;
                else if (ok != 0) e_nxt = 1;
                else e_nxt = wd_off ? 0 : 1;
            end
            e_flags = (rd ? 5'd0 : e_flags) | ok;
            m_done = lowp ? (m_done || e_req) : 0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        n_chk++;
        if (req !== e_req || irq !== e_irq || nxt !== e_nxt || flags !== e_flags) begin
            n_bad++;
            $display("FAIL %s cyc %0d: req/irq/nxt/flags actual %b/%b/%0d/%b expected %b/%b/%0d/%b",
                     tag, cyc, req, irq, nxt, flags, e_req, e_irq, e_nxt, e_flags);
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic leave_lp();
        mode = 0; evt = 0; pin_n = 1; tick(2);
        rd = 1; tick(1); rd = 0; tick(1);
    endtask

    task automatic pulse_evt(logic [1:0] m, logic [4:0] e);
        mode = m; tick(1);
        evt = e; tick(1);
        evt = 0; tick(3);
        leave_lp();
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tag = "R1"; tick(3);

        tag = "R2";
        for (int i = 0; i < 5; i++) pulse_evt(2'd1, 5'b1 << i);

        tag = "R3";
        pulse_evt(2'd2, 5'b00001); pulse_evt(2'd2, 5'b00010);
        pulse_evt(2'd2, 5'b00100); pulse_evt(2'd2, 5'b10000);

        tag = "R4";
        pulse_evt(2'd2, 5'b01000);

        tag = "R5";
        en = 5'b11110; pulse_evt(2'd1, 5'b00001); pulse_evt(2'd2, 5'b00001);
        en = 5'b01111; pulse_evt(2'd1, 5'b10000); pulse_evt(2'd2, 5'b10000);
        en = 5'h1f;

        tag = "R6";
        mode = 1; tick(1);
        pin_n = 0; tick(FL - 1); pin_n = 1; tick(3);
        pin_n = 0; tick(FL - 2); pin_n = 1; tick(1); pin_n = 0; tick(FL - 1); pin_n = 1; tick(3);
        pin_n = 0; tick(FL); pin_n = 1; tick(3);
        leave_lp();

        tag = "R7";
        wd_off = 1; mode = 1; tick(1); pin_n = 0; tick(FL + 2); pin_n = 1; tick(2); leave_lp();
        wd_off = 0; mode = 1; tick(1); pin_n = 0; tick(FL + 2); pin_n = 1; tick(2); leave_lp();

        tag = "R8";
        mode = 2; tick(1); pin_n = 0; tick(3 * FL); pin_n = 1; tick(2); leave_lp();

        tag = "R9";
        pulse_evt(2'd1, 5'b10101);
        pulse_evt(2'd2, 5'b11011);

        tag = "R10";
        mode = 1; tick(1); evt = 5'b00001; tick(1); evt = 0; tick(2);
        evt = 5'b00010; tick(1); evt = 0; pin_n = 0; tick(FL + 2); pin_n = 1; tick(2);
        leave_lp();

        tag = "R11";
        mode = 1; tick(1); evt = 5'b00100; tick(1); evt = 0; tick(4); mode = 0; tick(3);
        mode = 1; tick(1); evt = 5'b00001; rd = 1; tick(1); evt = 0; rd = 0; tick(3);
        rd = 1; tick(1); rd = 0; tick(2); leave_lp();

        tag = "R12";
        mode = 0; evt = 5'h1f; pin_n = 0; tick(2 * FL);
        mode = 3; tick(2 * FL); evt = 0; pin_n = 1; tick(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule